// File: doc/BRIEF.md
# IPv4 Transmit Frame Builder

This block turns one request to send an IPv4 datagram into a finished Ethernet frame on a byte stream. A one-cycle start strobe captures a protocol number, a payload length and a destination IP address. The block then asks an external address-resolution interface for the destination MAC address. Once it has that address, it raises a request for the shared MAC channel and waits for the grant.

After the grant, the block emits the 14-byte Ethernet header and then a 20-byte IPv4 header with a computed checksum. It then opens a pass-through so that the user's payload bytes flow to the MAC. Both byte interfaces use valid/ready.

- Outgoing stream: a byte transfers on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, header bytes hold and do not advance.
- Payload side: `pl_ready` is simply `tx_ready` gated by the payload phase, so back-pressure from the MAC reaches the user in the same cycle.

A two-bit status output shows where the current request stands.

Top module: `ipv4_frame_tx`

## Requirements
- R1: During and after a reset with no start, `lookup_req`, `chan_req`, `tx_valid`, `tx_last` and `pl_ready` are low and `status` is 00 (none).
- R2: A start strobe while idle captures the request fields. From the next cycle `lookup_req` is high, `lookup_dst_ip` shows the captured destination and `status` is 01 (sending).
- R3: `lookup_req` stays high until `lookup_done` is sampled high. On the following cycle `lookup_req` is low and `chan_req` is high.
- R4: `chan_req` stays high through the whole frame and is low on the cycle after the final byte transfers.
- R5: `tx_valid` stays low until the channel grant has been sampled on a cycle where `tx_ready` is also high.
- R6: The header goes out in this order: destination MAC, source MAC (`local_mac`), ethertype 0x0800, then the IPv4 header, each field most-significant byte first. Header bytes advance only on cycles with `tx_ready` high, and none is lost or repeated across a stall.
- R7: `pl_ready` is high only after all 34 header bytes have transferred, and only on cycles where `tx_ready` is high.
- R8: During the payload, `tx_valid` follows `pl_valid`. A cycle with `pl_valid` low produces no output byte, and the payload bytes appear unchanged and in order.
- R9: `pl_last` passes through to `tx_last` with the final payload byte. From the next cycle `status` is 10 (sent) and stays so until the next start.
- R10: The IPv4 header holds the following fields:
  - byte 0x45, then TOS 0;
  - total length equal to the payload length plus 20;
  - identification 0, then the flag/offset word 0x4000;
  - TTL 128, then the captured protocol;
  - the ones'-complement checksum of the ten header words, taken with the checksum word as zero;
  - `local_ip`, then the destination IP.
- R11: If `lookup_fail` is sampled while `lookup_req` is high, `status` becomes 11 (error) on the next cycle, and `chan_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a datagram |
| req_proto | input | 8 | IP protocol number |
| req_len | input | 16 | Payload length in bytes |
| req_dst_ip | input | 32 | Destination IP address |
| local_ip | input | 32 | Own IP address (static) |
| local_mac | input | 48 | Own MAC address (static) |
| lookup_req | output | 1 | Address-resolution request |
| lookup_dst_ip | output | 32 | IP address being resolved |
| lookup_done | input | 1 | Resolution succeeded, `lookup_mac` valid |
| lookup_fail | input | 1 | Resolution failed |
| lookup_mac | input | 48 | Resolved destination MAC |
| chan_req | output | 1 | Request for the MAC channel |
| chan_grant | input | 1 | MAC channel granted |
| pl_valid | input | 1 | Payload byte valid |
| pl_last | input | 1 | Final payload byte |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Block accepts a payload byte |
| tx_valid | output | 1 | Output byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_data | output | 8 | Output byte |
| tx_ready | input | 1 | Downstream accepts a byte |
| status | output | 2 | 00 none, 01 sending, 10 sent, 11 error |

## Verification
The bench stalls the MAC side with a periodic ready pattern while the header is streaming. A design that advanced its byte counter without a handshake would drop or repeat bytes, and the byte scoreboard would catch the mismatch. It grants the channel while ready is still low, so a design that raised valid on the grant alone is caught. It inserts payload gaps and MAC stalls mid-payload to expose a pass-through that forwarded stale bytes or ignored back-pressure. It also recomputes the header checksum over two different address sets, so a wrong fold or a missing complement shows up as a byte mismatch. Finally, a failed lookup must give the error status without the channel ever being requested.

// File: rtl/ipv4tx_pkg.sv
package ipv4tx_pkg;
  localparam int ETH_HDR_BYTES = 14;
  localparam int IP_HDR_BYTES  = 20;
  localparam int HDR_BYTES     = ETH_HDR_BYTES + IP_HDR_BYTES;
  localparam int HDR_IDX_W     = $clog2(HDR_BYTES);

  typedef enum logic [1:0] {
    ST_NONE    = 2'b00,
    ST_SENDING = 2'b01,
    ST_SENT    = 2'b10,
    ST_ERROR   = 2'b11
  } tx_status_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LOOKUP, PH_GRANT, PH_HDR, PH_PAYLOAD
  } tx_phase_t;
endpackage

// File: rtl/ipv4tx_csum.sv
module ipv4tx_csum #(
  parameter int WORDS = 10
) (
  input  logic [WORDS*16-1:0] hdr_words,
  output logic [15:0]         csum
);
  localparam int ACC_W = 16 + $clog2(WORDS) + 1;
  logic [ACC_W-1:0] acc;
  logic [16:0]      fold1;
  always_comb begin
    acc = '0;
    for (int w = 0; w < WORDS; w++)
      acc = acc + ACC_W'(hdr_words[w*16 +: 16]);
    fold1 = 17'(acc[15:0]) + 17'(acc[ACC_W-1:16]);
    csum  = ~(fold1[15:0] + 16'(fold1[16]));
  end
endmodule

// File: rtl/ipv4tx_hdr_mux.sv
module ipv4tx_hdr_mux
  import ipv4tx_pkg::*;
#(
  parameter logic [7:0] TTL = 8'd128
) (
  input  logic [HDR_IDX_W-1:0] idx,
  input  logic [47:0]          dst_mac,
  input  logic [47:0]          src_mac,
  input  logic [31:0]          src_ip,
  input  logic [31:0]          dst_ip,
  input  logic [7:0]           proto,
  input  logic [15:0]          pay_len,
  output logic [7:0]           byte_out
);
  localparam int HBITS = HDR_BYTES * 8;
  logic [15:0]  tot_len, csum;
  logic [159:0] ip_zero_csum;
  logic [HBITS-1:0] hvec;

  assign tot_len = pay_len + 16'(IP_HDR_BYTES);
  assign ip_zero_csum = {8'h45, 8'h00, tot_len, 16'h0000, 16'h4000,
                         TTL, proto, 16'h0000, src_ip, dst_ip};

  ipv4tx_csum #(.WORDS(IP_HDR_BYTES/2)) csum_i (
    .hdr_words(ip_zero_csum),
    .csum     (csum)
  );

  assign hvec = {dst_mac, src_mac, 16'h0800,
                 8'h45, 8'h00, tot_len, 16'h0000, 16'h4000,
                 TTL, proto, csum, src_ip, dst_ip};

  always_comb begin
    byte_out = 8'h00;
    for (int b = 0; b < HDR_BYTES; b++)
      if (idx == HDR_IDX_W'(b)) byte_out = hvec[HBITS-1-8*b -: 8];
  end
endmodule

// File: rtl/ipv4tx_seq.sv
module ipv4tx_seq
  import ipv4tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [7:0]           req_proto,
  input  logic [15:0]          req_len,
  input  logic [31:0]          req_dst_ip,
  input  logic                 lookup_done,
  input  logic                 lookup_fail,
  input  logic [47:0]          lookup_mac,
  input  logic                 chan_grant,
  input  logic                 tx_ready,
  input  logic                 pl_valid,
  input  logic                 pl_last,
  output tx_phase_t            phase,
  output logic [HDR_IDX_W-1:0] hdr_idx,
  output tx_status_t           status,
  output logic [7:0]           lat_proto,
  output logic [15:0]          lat_len,
  output logic [31:0]          lat_dst_ip,
  output logic [47:0]          lat_dst_mac
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      status      <= ST_NONE;
      hdr_idx     <= '0;
      lat_proto   <= '0;
      lat_len     <= '0;
      lat_dst_ip  <= '0;
      lat_dst_mac <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          lat_proto  <= req_proto;
          lat_len    <= req_len;
          lat_dst_ip <= req_dst_ip;
          status     <= ST_SENDING;
          phase      <= PH_LOOKUP;
        end
        PH_LOOKUP: begin
          if (lookup_fail) begin
            status <= ST_ERROR;
            phase  <= PH_IDLE;
          end else if (lookup_done) begin
            lat_dst_mac <= lookup_mac;
            phase       <= PH_GRANT;
          end
        end
        PH_GRANT: if (chan_grant && tx_ready) begin
          hdr_idx <= '0;
          phase   <= PH_HDR;
        end
        PH_HDR: if (tx_ready) begin
          if (hdr_idx == HDR_IDX_W'(HDR_BYTES-1)) phase <= PH_PAYLOAD;
          else hdr_idx <= hdr_idx + 1'b1;
        end
        PH_PAYLOAD: if (pl_valid && tx_ready && pl_last) begin
          status <= ST_SENT;
          phase  <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipv4_frame_tx.sv
module ipv4_frame_tx
  import ipv4tx_pkg::*;
#(
  parameter logic [7:0] TTL = 8'd128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [7:0]  req_proto,
  input  logic [15:0] req_len,
  input  logic [31:0] req_dst_ip,
  input  logic [31:0] local_ip,
  input  logic [47:0] local_mac,
  output logic        lookup_req,
  output logic [31:0] lookup_dst_ip,
  input  logic        lookup_done,
  input  logic        lookup_fail,
  input  logic [47:0] lookup_mac,
  output logic        chan_req,
  input  logic        chan_grant,
  input  logic        pl_valid,
  input  logic        pl_last,
  input  logic [7:0]  pl_data,
  output logic        pl_ready,
  output logic        tx_valid,
  output logic        tx_last,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic [1:0]  status
);
  tx_phase_t            phase;
  tx_status_t           st;
  logic [HDR_IDX_W-1:0] hdr_idx;
  logic [7:0]           lat_proto, hdr_byte;
  logic [15:0]          lat_len;
  logic [31:0]          lat_dst_ip;
  logic [47:0]          lat_dst_mac;

  ipv4tx_seq seq_i (
    .clk, .rst, .start, .req_proto, .req_len, .req_dst_ip,
    .lookup_done, .lookup_fail, .lookup_mac, .chan_grant, .tx_ready,
    .pl_valid, .pl_last,
    .phase, .hdr_idx, .status(st),
    .lat_proto, .lat_len, .lat_dst_ip, .lat_dst_mac
  );

  ipv4tx_hdr_mux #(.TTL(TTL)) hdr_i (
    .idx(hdr_idx), .dst_mac(lat_dst_mac), .src_mac(local_mac),
    .src_ip(local_ip), .dst_ip(lat_dst_ip), .proto(lat_proto),
    .pay_len(lat_len), .byte_out(hdr_byte)
  );

  assign status        = st;
  assign lookup_req    = (phase == PH_LOOKUP);
  assign lookup_dst_ip = lat_dst_ip;
  assign chan_req      = (phase == PH_GRANT) || (phase == PH_HDR) || (phase == PH_PAYLOAD);
  assign pl_ready      = (phase == PH_PAYLOAD) && tx_ready;

  always_comb begin
    tx_valid = 1'b0;
    tx_last  = 1'b0;
    tx_data  = 8'h00;
    if (phase == PH_HDR) begin
      tx_valid = 1'b1;
      tx_data  = hdr_byte;
    end else if (phase == PH_PAYLOAD) begin
      tx_valid = pl_valid;
      tx_last  = pl_valid && pl_last;
      tx_data  = pl_data;
    end
  end
endmodule

// File: rtl/ipv4_frame_tx_chk.sv
module ipv4_frame_tx_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [7:0]  req_proto,
  input logic [15:0] req_len,
  input logic [31:0] req_dst_ip,
  input logic [31:0] local_ip,
  input logic [47:0] local_mac,
  input logic        lookup_req,
  input logic [31:0] lookup_dst_ip,
  input logic        lookup_done,
  input logic        lookup_fail,
  input logic [47:0] lookup_mac,
  input logic        chan_req,
  input logic        chan_grant,
  input logic        pl_valid,
  input logic        pl_last,
  input logic [7:0]  pl_data,
  input logic        pl_ready,
  input logic        tx_valid,
  input logic        tx_last,
  input logic [7:0]  tx_data,
  input logic        tx_ready,
  input logic [1:0]  status
);
  // R2
  start_to_lookup_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !lookup_req && !chan_req) |=> (lookup_req && status == 2'b01 && lookup_dst_ip == $past(req_dst_ip)));

  // R3
  found_to_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (lookup_req && lookup_done && !lookup_fail) |=> (!lookup_req && chan_req));

  // R3
  lookup_chan_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(lookup_req && chan_req));

  // R5
  valid_needs_chan_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> chan_req);

  // R7
  pl_ready_follows_chk: assert property (@(posedge clk) disable iff (rst)
    pl_ready |-> (tx_ready && chan_req));

  // R4
  release_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_last) |=> (!chan_req && status == 2'b10));

  // R11
  fail_to_error_chk: assert property (@(posedge clk) disable iff (rst)
    (lookup_req && lookup_fail) |=> (status == 2'b11 && !chan_req));

  // R6
  hdr_stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !pl_ready && chan_req && $past(tx_valid) && !$past(pl_valid) && !pl_valid)
      |=> (tx_valid && $stable(tx_data)));
endmodule

bind ipv4_frame_tx ipv4_frame_tx_chk chk_i (.*);

// File: tb/ipv4_frame_tx_tb_top.sv
module ipv4_frame_tx_tb_top;
  localparam int HDR = 34;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  req_proto = '0;
  logic [15:0] req_len = '0;
  logic [31:0] req_dst_ip = '0;
  logic [31:0] local_ip = 32'hC0A8_0509;
  logic [47:0] local_mac = 48'h0023_2021_2223;
  logic        lookup_req;
  logic [31:0] lookup_dst_ip;
  logic        lookup_done = 1'b0, lookup_fail = 1'b0;
  logic [47:0] lookup_mac = '0;
  logic        chan_req;
  logic        chan_grant = 1'b0;
  logic        pl_valid = 1'b0, pl_last = 1'b0;
  logic [7:0]  pl_data = '0;
  logic        pl_ready, tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic [1:0]  status;

  int n_chk = 0, n_bad = 0;
  logic [8:0] expq[$];
  int hdr_seen = 0;
  bit ready_pat = 1'b0, ready_hold = 1'b0;
  int cyc = 0;

  always #5 clk = ~clk;

  ipv4_frame_tx dut_i (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // downstream ready driver
  always @(posedge clk) begin
    #1;
    cyc++;
    tx_ready = ready_pat ? ((cyc % 4) != 2) : ready_hold;
  end

  // scoreboard monitor: a transfer seen at negedge completes at the next posedge
  always @(negedge clk) begin
    if (!rst && pl_ready) check(tx_ready && hdr_seen >= HDR, "R7 pl_ready early", 64'(hdr_seen), 64'(HDR));
    if (!rst && tx_valid && tx_ready) begin
      if (expq.size() == 0) check(1'b0, "R6 unexpected byte", 64'(tx_data), 64'h0);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        check(tx_data == e[7:0], "R6/R8/R10 byte", 64'(tx_data), 64'(e[7:0]));
        check(tx_last == e[8], "R9 last flag", 64'(tx_last), 64'(e[8]));
      end
      hdr_seen++;
    end
  end

  function automatic logic [15:0] ref_csum(input logic [7:0] b[20]);
    logic [31:0] s = 0;
    for (int i = 0; i < 20; i += 2) s += {b[i], b[i+1]};
    while (s[31:16] != 0) s = s[15:0] + s[31:16];
    return ~s[15:0];
  endfunction

  task automatic push_header(input logic [47:0] dmac, input logic [7:0] pr,
                             input logic [15:0] len, input logic [31:0] dip);
    logic [7:0] ip[20];
    logic [15:0] tl, cs;
    tl = len + 16'd20;
    ip = '{8'h45, 8'h00, tl[15:8], tl[7:0], 8'h00, 8'h00, 8'h40, 8'h00, 8'h80, pr,
           8'h00, 8'h00, local_ip[31:24], local_ip[23:16], local_ip[15:8], local_ip[7:0],
           dip[31:24], dip[23:16], dip[15:8], dip[7:0]};
    cs = ref_csum(ip);
    ip[10] = cs[15:8];
    ip[11] = cs[7:0];
    for (int i = 5; i >= 0; i--) expq.push_back({1'b0, dmac[i*8 +: 8]});
    for (int i = 5; i >= 0; i--) expq.push_back({1'b0, local_mac[i*8 +: 8]});
    expq.push_back(9'h008);
    expq.push_back(9'h000);
    for (int i = 0; i < 20; i++) expq.push_back({1'b0, ip[i]});
  endtask

  task automatic send_frame(input logic [7:0] pr, input logic [15:0] len, input logic [31:0] dip,
                            input logic [47:0] dmac, input int arp_wait, input int grant_wait,
                            input bit stall_pat, input logic [7:0] seed);
    hdr_seen = 0;
    ready_pat = 1'b0; ready_hold = 1'b0;
    push_header(dmac, pr, len, dip);
    for (int i = 0; i < len; i++) expq.push_back({(i == len - 1), 8'(seed + i)});
    req_proto = pr; req_len = len; req_dst_ip = dip; start = 1'b1;
    tick();
    start = 1'b0;
    check(lookup_req == 1'b1, "R2 lookup_req", 64'(lookup_req), 64'h1);
    check(status == 2'b01, "R2 status sending", 64'(status), 64'h1);
    check(lookup_dst_ip == dip, "R2 lookup ip", 64'(lookup_dst_ip), 64'(dip));
    for (int i = 0; i < arp_wait; i++) tick();
    check(lookup_req == 1'b1 && chan_req == 1'b0, "R3 lookup held", 64'(lookup_req), 64'h1);
    lookup_done = 1'b1; lookup_mac = dmac;
    tick();
    lookup_done = 1'b0;
    check(lookup_req == 1'b0, "R3 lookup_req drops", 64'(lookup_req), 64'h0);
    check(chan_req == 1'b1, "R3 chan_req rises", 64'(chan_req), 64'h1);
    for (int i = 0; i < grant_wait; i++) tick();
    chan_grant = 1'b1;
    tick(); tick();
    check(tx_valid == 1'b0, "R5 valid before ready", 64'(tx_valid), 64'h0);
    ready_hold = 1'b1;
    ready_pat = stall_pat;
    // payload: wait for the payload phase, then stream with one gap
    for (int i = 0; i < len; i++) begin
      if (i == 2) begin
        pl_valid = 1'b0;
        @(negedge clk);
        check(tx_valid == 1'b0, "R8 gap gives no byte", 64'(tx_valid), 64'h0);
        tick();
      end
      pl_valid = 1'b1; pl_data = 8'(seed + i); pl_last = (i == len - 1);
      @(negedge clk);
      while (!pl_ready) @(negedge clk);
      check(chan_req == 1'b1, "R4 chan_req held", 64'(chan_req), 64'h1);
      tick();
    end
    pl_valid = 1'b0; pl_last = 1'b0;
    check(chan_req == 1'b0, "R4 chan_req released", 64'(chan_req), 64'h0);
    check(status == 2'b10, "R9 status sent", 64'(status), 64'h2);
    check(expq.size() == 0, "R6 all bytes out", 64'(expq.size()), 64'h0);
    chan_grant = 1'b0;
    tick(); tick(); tick();
    check(status == 2'b10 && tx_valid == 1'b0, "R9 sent held", 64'(status), 64'h2);
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 64'h0, 64'h0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) tick();
    check(!lookup_req && !chan_req && !tx_valid && !tx_last && !pl_ready, "R1 outputs low",
          64'({lookup_req, chan_req, tx_valid, tx_last, pl_ready}), 64'h0);
    check(status == 2'b00, "R1 status none", 64'(status), 64'h0);
    rst = 1'b0;
    repeat (3) tick();
    check(!lookup_req && !chan_req && !tx_valid && !pl_ready && status == 2'b00, "R1 idle after reset",
          64'({lookup_req, chan_req, tx_valid, pl_ready, status}), 64'h0);

    // frame with delays and stalls (R6 stall, R10 header fields)
    send_frame(8'h35, 16'd8, 32'hC012_3478, 48'h0504_2327_1016, 10, 10, 1'b1, 8'h56);
    // frame with no delays and a different address set
    local_ip = 32'h0A00_00FE; local_mac = 48'hA1B2_C3D4_E5F6;
    send_frame(8'h11, 16'd6, 32'hFFFF_0001, 48'h1122_3344_5566, 0, 0, 1'b0, 8'hC1);

    // failed lookup (R11)
    req_dst_ip = 32'h0101_0101; start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    lookup_fail = 1'b1;
    tick();
    lookup_fail = 1'b0;
    check(status == 2'b11, "R11 status error", 64'(status), 64'h3);
    for (int i = 0; i < 4; i++) begin
      check(chan_req == 1'b0 && lookup_req == 1'b0, "R11 no channel request", 64'(chan_req), 64'h0);
      tick();
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule